// File: doc/BRIEF.md
# Code-Keyed Memory Access Guard

This block decides, in the same cycle as the request, whether a data read or write may proceed. The decision depends on the code that is running at the time, not on a privilege mode. Memory is carved into address windows. Each window belongs to a numbered link, and a link gathers the code, data and stack of one isolated thread. A permission matrix says which data links each code link may read, write, or both. The code link for a request is the link of the window that holds the current program counter.

The guard also polices control transfers between threads. A call, branch or return that lands in a different link is allowed only at that link's registered entry address or registered return address. Any other target raises a crossing fault. When a crossing is allowed, the stack pointer select moves to the target link in the same cycle, and it stays there until the next allowed crossing.

All windows, permissions, entry and return addresses and per-link stack pointers are written through a simple configuration write port. The surrounding bus fabric is not part of the block.

Top module: `cguard_top`

## Requirements
- R1: A window matches an address when the window is enabled and base <= address <= limit, with both bounds inclusive. When windows overlap, the lowest-numbered matching window sets the link.
- R2: A data request whose program counter or data address matches no window faults in the same cycle with cause 0.
- R3: A read is granted only when bit 0 of the matrix entry for [code link][data link] is set. Otherwise it faults with cause 1.
- R4: A write is granted only when bit 1 of that entry is set. Otherwise it faults with cause 2.
- R5: The code link used for the matrix lookup is the link of the window that holds the current program counter. The same data address can therefore be granted under one program counter and refused under another.
- R6: A transfer whose target lies in the same link as the program counter is granted, whatever the target address.
- R7: A transfer into a different link is granted only when the target equals that link's entry address or its return address. Any other target faults with cause 3.
- R8: A transfer whose target or program counter matches no window faults with cause 0.
- R9: On a granted crossing, the stack select and the active stack pointer show the target link in the same cycle. After the clock edge they keep that link until another crossing is granted. Faulted crossings and transfers within one link leave them unchanged.
- R10: After reset, every window is disabled, every permission is zero, and the active link is 0. With no request valid, neither grant nor fault is asserted.
- R11: A configuration write uses address {group[2:0], index[2:0]}. The groups are: 0 = window base, 1 = window limit, 2 = window link (data[2:0] link, data[4] enable), 3 = matrix row for code link index (data link d in bits [2d+1:2d]), 4 = entry address, 5 = return address, 6 = stack pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration register address {group, index} |
| cfg_wdata | input | 32 | Configuration write data |
| exec_pc | input | 32 | Address of the instruction now executing |
| acc_valid | input | 1 | Data request present |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 32 | Data address |
| acc_grant | output | 1 | Data request allowed |
| acc_fault | output | 1 | Data request refused |
| acc_cause | output | 2 | Fault cause for the data request |
| xfer_valid | input | 1 | Control transfer present |
| xfer_target | input | 32 | Transfer target address |
| xfer_grant | output | 1 | Transfer allowed |
| xfer_fault | output | 1 | Transfer refused |
| xfer_cause | output | 2 | Fault cause for the transfer |
| sp_sel | output | 3 | Link whose stack pointer is active |
| active_sp | output | 32 | Stack pointer value of the active link |

## Verification
On every cycle the assertions check four things: that a granted write or read really has the matching matrix bit, that unmapped requests fault with cause 0, that the outputs stay quiet without a request, and that the active link moves only after a granted transfer and then shows that transfer's target. Only the bench scenarios can show the rest: the inclusive window bounds, which window wins on overlap, the fact that the result for the same data address depends on the program counter, and the exact set of entry and return addresses a crossing accepts.

// File: rtl/cguard_pkg.sv
package cguard_pkg;
    localparam int NREG  = 8;
    localparam int NLINK = 8;
    localparam int AW    = 32;
    localparam int LW    = $clog2(NLINK);
    localparam int IDXW  = 3;
    localparam int GRPW  = 3;
    localparam int CFGW  = GRPW + IDXW;

    typedef logic [LW-1:0] link_t;
    typedef logic [AW-1:0] addr_t;
    typedef logic [1:0]    perm_t;
    typedef perm_t [NLINK-1:0] perm_row_t;
    typedef perm_row_t [NLINK-1:0] perm_mx_t;
    typedef addr_t [NLINK-1:0] link_addr_t;

    typedef enum logic [1:0] {
        CZ_NOREGION = 2'd0,
        CZ_RDENY    = 2'd1,
        CZ_WRDENY   = 2'd2,
        CZ_CROSS    = 2'd3
    } cause_e;

    typedef enum logic [GRPW-1:0] {
        G_BASE  = 3'd0,
        G_LIM   = 3'd1,
        G_LINK  = 3'd2,
        G_PERM  = 3'd3,
        G_ENTRY = 3'd4,
        G_RET   = 3'd5,
        G_STACK = 3'd6
    } cfg_grp_e;

    localparam int EN_BIT = 4;

    typedef struct packed {
        logic  en;
        link_t link;
        addr_t base;
        addr_t limit;
    } region_t;

    typedef region_t [NREG-1:0] region_arr_t;

    function automatic logic covers(region_t r, addr_t a);
        return r.en && (a >= r.base) && (a <= r.limit);
    endfunction

    function automatic logic perm_ok(perm_t p, logic wr);
        return wr ? p[1] : p[0];
    endfunction
endpackage

// File: rtl/cguard_cfg.sv
module cguard_cfg
    import cguard_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFGW-1:0]   cfg_addr,
    input  logic [AW-1:0]     cfg_wdata,
    output region_arr_t       regions,
    output perm_mx_t          perm,
    output link_addr_t        entry_pt,
    output link_addr_t        ret_pt,
    output link_addr_t        stack_pt
);
    logic [GRPW-1:0] grp;
    logic [IDXW-1:0] idx;

    assign grp = cfg_addr[CFGW-1:IDXW];
    assign idx = cfg_addr[IDXW-1:0];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic hit_i;
        assign hit_i = cfg_we && (idx == IDXW'(i));
        always_ff @(posedge clk) begin
            if (rst) begin
                regions[i] <= '0;
            end else if (hit_i) begin
                case (grp)
                    G_BASE: regions[i].base  <= cfg_wdata;
                    G_LIM:  regions[i].limit <= cfg_wdata;
                    G_LINK: begin
                        regions[i].link <= cfg_wdata[LW-1:0];
                        regions[i].en   <= cfg_wdata[EN_BIT];
                    end
                    default: ;
                endcase
            end
        end
    end

    for (genvar l = 0; l < NLINK; l++) begin : g_link
        logic hit_l;
        assign hit_l = cfg_we && (idx == IDXW'(l));
        always_ff @(posedge clk) begin
            if (rst) begin
                perm[l]     <= '0;
                entry_pt[l] <= '0;
                ret_pt[l]   <= '0;
                stack_pt[l] <= '0;
            end else if (hit_l) begin
                case (grp)
                    G_PERM:  perm[l]     <= cfg_wdata[2*NLINK-1:0];
                    G_ENTRY: entry_pt[l] <= cfg_wdata;
                    G_RET:   ret_pt[l]   <= cfg_wdata;
                    G_STACK: stack_pt[l] <= cfg_wdata;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/cguard_match.sv
module cguard_match
    import cguard_pkg::*;
(
    input  region_arr_t regions,
    input  addr_t       addr,
    output logic        hit,
    output link_t       link
);
    always_comb begin
        hit  = 1'b0;
        link = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (covers(regions[i], addr)) begin
                hit  = 1'b1;
                link = regions[i].link;
            end
        end
    end
endmodule

// File: rtl/cguard_datachk.sv
module cguard_datachk
    import cguard_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     acc_valid,
    input  logic     acc_write,
    input  logic     pc_hit,
    input  link_t    pc_link,
    input  logic     d_hit,
    input  link_t    d_link,
    input  perm_mx_t perm,
    output logic     grant,
    output logic     fault,
    output cause_e   cause
);
    perm_t entry_bits;
    assign entry_bits = perm[pc_link][d_link];

    always_comb begin
        grant = 1'b0;
        fault = 1'b0;
        cause = CZ_NOREGION;
        if (acc_valid) begin
            if (!pc_hit || !d_hit) begin
                fault = 1'b1;
                cause = CZ_NOREGION;
            end else if (perm_ok(entry_bits, acc_write)) begin
                grant = 1'b1;
            end else begin
                fault = 1'b1;
                cause = acc_write ? CZ_WRDENY : CZ_RDENY;
            end
        end
    end

    // R4
    wr_needs_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && grant) |-> perm[pc_link][d_link][1]);

    // R3
    rd_needs_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_write && grant) |-> perm[pc_link][d_link][0]);

    // R2
    unmapped_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && (!pc_hit || !d_hit)) |-> (fault && cause == CZ_NOREGION));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |-> (!grant && !fault));
endmodule

// File: rtl/cguard_xfer.sv
module cguard_xfer
    import cguard_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       xfer_valid,
    input  addr_t      target,
    input  logic       src_hit,
    input  link_t      src_link,
    input  logic       tgt_hit,
    input  link_t      tgt_link,
    input  link_addr_t entry_pt,
    input  link_addr_t ret_pt,
    input  link_addr_t stack_pt,
    output logic       grant,
    output logic       fault,
    output cause_e     cause,
    output link_t      sp_sel,
    output addr_t      active_sp
);
    link_t cur_link;
    logic  crossing;
    logic  at_gate;

    assign crossing = (tgt_link != src_link);
    assign at_gate  = (target == entry_pt[tgt_link]) || (target == ret_pt[tgt_link]);

    always_comb begin
        grant = 1'b0;
        fault = 1'b0;
        cause = CZ_NOREGION;
        if (xfer_valid) begin
            if (!src_hit || !tgt_hit) begin
                fault = 1'b1;
                cause = CZ_NOREGION;
            end else if (!crossing || at_gate) begin
                grant = 1'b1;
            end else begin
                fault = 1'b1;
                cause = CZ_CROSS;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_link <= '0;
        end else if (grant && crossing) begin
            cur_link <= tgt_link;
        end
    end

    assign sp_sel    = (grant && crossing) ? tgt_link : cur_link;
    assign active_sp = stack_pt[sp_sel];

    // R9
    link_moves_on_grant_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(cur_link) |-> $past(grant));

    // R9
    sp_follows_target_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(grant && crossing && !rst) && !xfer_valid) |-> (sp_sel == $past(tgt_link)));

    // R7
    xfer_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(grant && fault));
endmodule

// File: rtl/cguard_top.sv
module cguard_top
    import cguard_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [5:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    input  logic [31:0] exec_pc,
    input  logic        acc_valid,
    input  logic        acc_write,
    input  logic [31:0] acc_addr,
    output logic        acc_grant,
    output logic        acc_fault,
    output logic [1:0]  acc_cause,
    input  logic        xfer_valid,
    input  logic [31:0] xfer_target,
    output logic        xfer_grant,
    output logic        xfer_fault,
    output logic [1:0]  xfer_cause,
    output logic [2:0]  sp_sel,
    output logic [31:0] active_sp
);
    region_arr_t regions;
    perm_mx_t    perm;
    link_addr_t  entry_pt, ret_pt, stack_pt;

    logic   pc_hit, d_hit, t_hit;
    link_t  pc_link, d_link, t_link;
    cause_e dcause, xcause;

    cguard_cfg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .regions  (regions),
        .perm     (perm),
        .entry_pt (entry_pt),
        .ret_pt   (ret_pt),
        .stack_pt (stack_pt)
    );

    cguard_match u_pc_match  (.regions(regions), .addr(exec_pc),     .hit(pc_hit), .link(pc_link));
    cguard_match u_dat_match (.regions(regions), .addr(acc_addr),    .hit(d_hit),  .link(d_link));
    cguard_match u_tgt_match (.regions(regions), .addr(xfer_target), .hit(t_hit),  .link(t_link));

    cguard_datachk u_dchk (
        .clk      (clk),
        .rst      (rst),
        .acc_valid(acc_valid),
        .acc_write(acc_write),
        .pc_hit   (pc_hit),
        .pc_link  (pc_link),
        .d_hit    (d_hit),
        .d_link   (d_link),
        .perm     (perm),
        .grant    (acc_grant),
        .fault    (acc_fault),
        .cause    (dcause)
    );

    cguard_xfer u_xfer (
        .clk       (clk),
        .rst       (rst),
        .xfer_valid(xfer_valid),
        .target    (xfer_target),
        .src_hit   (pc_hit),
        .src_link  (pc_link),
        .tgt_hit   (t_hit),
        .tgt_link  (t_link),
        .entry_pt  (entry_pt),
        .ret_pt    (ret_pt),
        .stack_pt  (stack_pt),
        .grant     (xfer_grant),
        .fault     (xfer_fault),
        .cause     (xcause),
        .sp_sel    (sp_sel),
        .active_sp (active_sp)
    );

    assign acc_cause  = dcause;
    assign xfer_cause = xcause;
endmodule

// File: tb/cguard_top_test.sv
module cguard_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] exec_pc = '0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_grant, acc_fault;
    logic [1:0]  acc_cause;
    logic        xfer_valid = 1'b0;
    logic [31:0] xfer_target = '0;
    logic        xfer_grant, xfer_fault;
    logic [1:0]  xfer_cause;
    logic [2:0]  sp_sel;
    logic [31:0] active_sp;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    cguard_top uut (.*);

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg(logic [2:0] grp, logic [2:0] idx, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = {grp, idx}; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // result packed as {grant, fault, cause}
    task automatic data_req(string tag, logic [31:0] pc, logic [31:0] a, logic wr, logic [3:0] exp);
        @(negedge clk);
        exec_pc = pc; acc_addr = a; acc_write = wr; acc_valid = 1'b1;
        #2;
        check(tag, {28'd0, acc_grant, acc_fault, acc_cause}, {28'd0, exp});
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic xfer_req(string tag, logic [31:0] pc, logic [31:0] t, logic [3:0] exp,
                            logic [2:0] sel_now, logic [2:0] sel_after);
        @(negedge clk);
        exec_pc = pc; xfer_target = t; xfer_valid = 1'b1;
        #2;
        check({tag, " result"}, {28'd0, xfer_grant, xfer_fault, xfer_cause}, {28'd0, exp});
        check({tag, " sel"}, {29'd0, sp_sel}, {29'd0, sel_now});
        check({tag, " sp"}, active_sp, 32'hA000 + 32'h100 * sel_now);
        @(negedge clk);
        xfer_valid = 1'b0;
        #1;
        check({tag, " held sel"}, {29'd0, sp_sel}, {29'd0, sel_after});
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check("R10 idle grant/fault", {30'd0, acc_grant, acc_fault}, 32'd0);
        check("R10 sel", {29'd0, sp_sel}, 32'd0);
        check("R10 sp", active_sp, 32'd0);
        rst = 1'b0;
        // R10 all windows disabled -> unmapped
        data_req("R10 no window after reset", 32'h1010, 32'h8010, 1'b0, 4'b0100);
    endtask

    task automatic t_config;
        // R11 layout
        cfg(3'd0, 3'd0, 32'h1000); cfg(3'd1, 3'd0, 32'h1FFF); cfg(3'd2, 3'd0, 32'h11);
        cfg(3'd0, 3'd1, 32'h2000); cfg(3'd1, 3'd1, 32'h2FFF); cfg(3'd2, 3'd1, 32'h12);
        cfg(3'd0, 3'd2, 32'h8000); cfg(3'd1, 3'd2, 32'h80FF); cfg(3'd2, 3'd2, 32'h13);
        cfg(3'd0, 3'd3, 32'h8000); cfg(3'd1, 3'd3, 32'h8FFF); cfg(3'd2, 3'd3, 32'h14);
        cfg(3'd3, 3'd1, 32'h1C0);
        cfg(3'd3, 3'd2, 32'h200);
        cfg(3'd4, 3'd1, 32'h1100); cfg(3'd5, 3'd1, 32'h1180);
        cfg(3'd4, 3'd2, 32'h2100); cfg(3'd5, 3'd2, 32'h2200);
        for (int l = 0; l < 8; l++) cfg(3'd6, 3'(l), 32'hA000 + 32'h100 * l);
        #1;
        check("R11 stack pointer write link0", active_sp, 32'hA000);
    endtask

    task automatic t_perm;
        data_req("R3 read granted bit0", 32'h1010, 32'h8010, 1'b0, 4'b1000);
        data_req("R4 write granted bit1", 32'h1010, 32'h8010, 1'b1, 4'b1000);
        data_req("R3 read-only link read", 32'h1010, 32'h8200, 1'b0, 4'b1000);
        data_req("R4 read-only link write denied", 32'h1010, 32'h8200, 1'b1, 4'b0110);
        data_req("R4 write-only link write", 32'h2010, 32'h8200, 1'b1, 4'b1000);
        data_req("R3 write-only link read denied", 32'h2010, 32'h8200, 1'b0, 4'b0101);
    endtask

    task automatic t_pc_keyed;
        data_req("R5 pc link1 reads link3", 32'h1FFF, 32'h8040, 1'b0, 4'b1000);
        data_req("R5 pc link2 refused link3", 32'h2000, 32'h8040, 1'b0, 4'b0101);
    endtask

    task automatic t_windows;
        data_req("R1 base inclusive", 32'h2010, 32'h8000, 1'b0, 4'b0101);
        data_req("R1 limit inclusive low wins", 32'h2010, 32'h80FF, 1'b1, 4'b0110);
        data_req("R1 past limit falls to next", 32'h2010, 32'h8100, 1'b1, 4'b1000);
        data_req("R2 data below window", 32'h1010, 32'h7FFF, 1'b0, 4'b0100);
        data_req("R2 data above window", 32'h1010, 32'h9000, 1'b1, 4'b0100);
        data_req("R2 pc unmapped", 32'h5000, 32'h8010, 1'b0, 4'b0100);
    endtask

    task automatic t_cross;
        xfer_req("R9 R7 entry into link1", 32'h2010, 32'h1100, 4'b1000, 3'd1, 3'd1);
        xfer_req("R7 bad target link2", 32'h1010, 32'h2050, 4'b0111, 3'd1, 3'd1);
        xfer_req("R7 return point link2", 32'h1010, 32'h2200, 4'b1000, 3'd2, 3'd2);
        xfer_req("R7 return point link1", 32'h2010, 32'h1180, 4'b1000, 3'd1, 3'd1);
        xfer_req("R6 same link any target", 32'h1010, 32'h1504, 4'b1000, 3'd1, 3'd1);
        xfer_req("R8 target unmapped", 32'h1010, 32'h9000, 4'b0100, 3'd1, 3'd1);
        xfer_req("R8 pc unmapped", 32'h5000, 32'h2100, 4'b0100, 3'd1, 3'd1);
        xfer_req("R7 zero entry link3 refused", 32'h2010, 32'h8000, 4'b0111, 3'd1, 3'd1);
        xfer_req("R9 entry into link2", 32'h1010, 32'h2100, 4'b1000, 3'd2, 3'd2);
    endtask

    initial begin
        t_reset;
        t_config;
        t_perm;
        t_pc_keyed;
        t_windows;
        t_cross;
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule